// File: doc/BRIEF.md
# Channel Gate Generator

This block drives a single gating signal that follows T1 frame timing. It runs from the 1.544 MHz bit clock. It counts 193-bit frames, each made of one framing bit followed by twenty-four 8-bit timeslots. A downstream serial controller uses the output to skip timeslots, for example in fractional T1 or primary-rate ISDN links.

A 24-bit channel mask is kept in three byte-wide registers, written through a small write port. While a channel's mask bit is one, the output stays high for all eight bit times of that channel. While the bit is zero, the output stays low for that channel. The output is always low during the framing bit.

Writes first land in staging registers. They are copied into the live mask only at the start of a frame, so a channel's gating never changes part way through a channel. A frame-sync pulse realigns the counter at any time. A chip uses two instances of this block: one for the receive direction and one for the transmit direction, each with its own registers.

Top module: `chan_gate_gen`

## Requirements
- R1: After reset every mask bit is zero, so the output stays low through every bit of the following frame.
- R2: The output is low during the framing bit (bit position 0 of the frame).
- R3: Mask register address 0 holds channels 1 to 8, address 1 holds channels 9 to 16, and address 2 holds channels 17 to 24. Within a register, the lowest channel of the group is bit 0 and the channels ascend towards bit 7, so channel c is bit (c-1) mod 8 of register (c-1)/8.
- R4: When a channel's mask bit is 1, the output is high for all 8 bit times of that channel. Channel c occupies frame bit positions 8(c-1)+1 to 8(c-1)+8.
- R5: When a channel's mask bit is 0, the output is low for all 8 bit times of that channel.
- R6: Without a frame sync, the frame is 193 bit times long and the bit position wraps from 192 to 0.
- R7: A frameSync pulse sampled at a clock edge makes the next bit period the framing bit, whatever the current position.
- R8: A write reaches the live mask only at the next framing bit. The rest of the current frame keeps the old gating.
- R9: A write to address 3 changes no mask bit.
- R10: The output changes level only between channels, never between two bits of the same channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1.544 MHz bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame realign pulse; the next bit becomes the framing bit |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Mask register select (0, 1 or 2; 3 is ignored) |
| wrData | input | 8 | Mask byte; bit n belongs to channel 8*wrAddr+n+1 |
| gateOut | output | 1 | Channel gating output, high during masked-in timeslots |

## Verification
The output is registered, so it shows the state for a bit position in the same cycle that the counter reaches that position. Suppose frameSync is sampled at clock edge E. The framing bit is then visible in the cycle after E, and frame bit p is visible p cycles after that. A write sampled at an edge first appears at the next framing bit. The bench drives and samples on the falling edge. After each sync it walks all 193 bit positions one falling edge at a time and compares every position with the mask it expects to be live. It expects the old mask for the remainder of any frame in which a write occurred.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;
  localparam int NUM_CH      = 24;
  localparam int BITS_PER_CH = 8;
  localparam int REG_W       = 8;
  localparam int NUM_REGS    = NUM_CH / REG_W;
  localparam int FRAME_BITS  = NUM_CH * BITS_PER_CH + 1;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int ADDR_W      = 2;
  localparam int SLOT_SH     = $clog2(BITS_PER_CH);

  typedef struct packed {
    logic                loadMask;
    logic [NUM_REGS-1:0] wrSel;
    logic                slotValid;
    logic [CH_W-1:0]     chanIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/chan_gate_ctl.sv
module chan_gate_ctl
  import chan_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctlStrobes_t       strobes,
  output logic [CNT_W-1:0]  bitPos
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitNext;
  logic [CNT_W-1:0] slotOffs;

  always_comb begin
    if (frameSync || bitCnt == LAST_BIT) bitNext = '0;
    else                                 bitNext = bitCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else       bitCnt <= bitNext;
  end

  assign slotOffs = bitNext - CNT_W'(1);

  always_comb begin
    strobes.loadMask  = (bitNext == '0);
    strobes.slotValid = (bitNext != '0);
    strobes.chanIdx   = CH_W'(slotOffs >> SLOT_SH);
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_wrDecode
    assign strobes.wrSel[r] = wrEn && (wrAddr == ADDR_W'(r));
  end

  assign bitPos = bitCnt;
endmodule

// File: rtl/chan_gate_dp.sv
module chan_gate_dp
  import chan_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [REG_W-1:0] wrData,
  output logic             gateOut
);
  logic [NUM_CH-1:0] stagedMask;
  logic [NUM_CH-1:0] liveMask;
  logic              gateQ;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 stagedMask[r*REG_W +: REG_W] <= '0;
      else if (strobes.wrSel[r]) stagedMask[r*REG_W +: REG_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 liveMask <= '0;
    else if (strobes.loadMask) liveMask <= stagedMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= strobes.slotValid && liveMask[strobes.chanIdx];
  end

  assign gateOut = gateQ;
endmodule

// File: rtl/chan_gate_gen.sv
module chan_gate_gen
  import chan_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic              gateOut
);
  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] bitPos;

  chan_gate_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .strobes   (strobes),
    .bitPos    (bitPos)
  );

  chan_gate_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .gateOut (gateOut)
  );
endmodule

// File: rtl/chan_gate_gen_chk.sv
module chan_gate_gen_chk
  import chan_gate_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             gateOut,
  input logic [CNT_W-1:0] bitPos
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] IN_MASK  = CNT_W'(BITS_PER_CH - 1);

  logic [CNT_W-1:0] inSlot;
  assign inSlot = (bitPos - CNT_W'(1)) & IN_MASK;

  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !gateOut);

  p_frame_bit_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos == '0) |-> !gateOut);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && bitPos == LAST_BIT) |=> (bitPos == '0));

  p_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && bitPos != LAST_BIT) |=> (bitPos == CNT_W'($past(bitPos) + CNT_W'(1))));

  p_sync_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (bitPos == '0));

  p_steady_in_chan_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && bitPos != '0 && inSlot != IN_MASK) |=> $stable(gateOut));
endmodule

bind chan_gate_gen chan_gate_gen_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frameSync (frameSync),
  .gateOut   (gateOut),
  .bitPos    (bitPos)
);

// File: tb/chan_gate_gen_test.sv
`timescale 1ns/1ps
module chan_gate_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       gateOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  chan_gate_gen uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .gateOut(gateOut)
  );

  function automatic logic expGate(input logic [23:0] m, input int pos);
    if (pos == 0) return 1'b0;
    return m[(pos - 1) / 8];
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input int pos);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos %0d: gateOut=%b expected %b", req, pos, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeMask(input logic [23:0] m);
    writeReg(2'd0, m[7:0]);
    writeReg(2'd1, m[15:8]);
    writeReg(2'd2, m[23:16]);
  endtask

  task automatic doSync();
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  // Walks one frame from the framing bit; ends on the next framing bit.
  task automatic checkFrame(input logic [23:0] m, input string req);
    for (int p = 0; p < 193; p++) begin
      chk(gateOut, expGate(m, p), req, p);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    for (int p = 0; p < 200; p++) begin
      chk(gateOut, 1'b0, "R1", p);
      @(negedge clk);
    end
  endtask

  task automatic testMapping();
    writeMask(24'h000001); doSync(); checkFrame(24'h000001, "R3 R4 ch1");
    writeMask(24'h800000); doSync(); checkFrame(24'h800000, "R3 R4 ch24");
    writeMask(24'hA53C81); doSync(); checkFrame(24'hA53C81, "R3 R4 R5 R2");
    writeMask(24'hFFFFFF); doSync(); checkFrame(24'hFFFFFF, "R4 R2 all");
    writeMask(24'h000000); doSync(); checkFrame(24'h000000, "R5 none");
  endtask

  task automatic testFreeRun();
    writeMask(24'h5A0F33); doSync();
    checkFrame(24'h5A0F33, "R6 first");
    checkFrame(24'h5A0F33, "R6 wrap");
  endtask

  task automatic testResync();
    writeMask(24'h00F001); doSync();
    for (int p = 0; p < 37; p++) begin
      chk(gateOut, expGate(24'h00F001, p), "R7 pre", p);
      @(negedge clk);
    end
    doSync();
    checkFrame(24'h00F001, "R7 realigned");
  endtask

  task automatic testMidFrameWrite();
    writeMask(24'h0000C0); doSync();
    for (int p = 0; p < 193; p++) begin
      wrEn = 1'b0;
      chk(gateOut, expGate(24'h0000C0, p), "R8 old frame", p);
      if (p == 50) begin
        wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h01;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    checkFrame(24'h000001, "R8 new frame");
  endtask

  task automatic testBadAddr();
    writeMask(24'h000000);
    writeReg(2'd3, 8'hFF);
    doSync();
    checkFrame(24'h000000, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMapping();
    testFreeRun();
    testResync();
    testMidFrameWrite();
    testBadAddr();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule